// File: doc/BRIEF.md
# UART FIFO Status and Interrupt Unit

This unit sits between a UART's serial engines and its register bus. It holds characters in two queues. The transmit queue is filled by bus writes and drained by the transmitter's pop port. The receive queue is filled by the receiver's push port and drained by bus reads. From the two fill levels, the error bits of the oldest received word, a sticky overrun bit and a character-timeout detector, it builds a 10-bit status word. Status bits 0 to 8 are masked with an interrupt-enable register and ORed into one interrupt line.

Software can flush either queue by writing a one to a dedicated reset register. The queue mode input selects one of two capacities. In queued mode each queue holds 16 entries. In single-entry mode each queue acts as a one-word holding register. Serial framing and baud generation lie outside the unit. The baud logic supplies one pulse per character period on `char_tick_i`.

Register byte offsets are as follows: transmit buffer 0x04, receive buffer 0x08, interrupt enable 0x10, status 0x14, timeout 0x1C, transmit flush 0x20, receive flush 0x24. Reads return data combinationally for the address presented. Register updates and queue pops take effect at the clock edge of the access cycle.

Top module: `uart_fifo_status`

## Requirements
- R1: After reset, status reads 0x006 (transmit empty and transmit half empty), the enable register reads 0, the timeout register reads 20, `irq_o` is low and `tx_valid_o` is low.
- R2: A write to 0x04 queues the low 9 bits of the write data. `tx_valid_o`/`tx_data_o` present the oldest entry, and a `tx_pop_i` cycle removes it, in first-in first-out order.
- R3: A write to a full transmit queue is dropped. In queued mode the queue holds exactly 16 words.
- R4: A read of 0x08 returns the oldest received 10-bit word and removes it. The word is laid out as bit 9 framing error, bit 8 parity error, bits 7:0 data. A read of an empty queue returns 0.
- R5: Status bits: 0 receive not empty; 1 transmit empty; 2 transmit at most half full (count <= 8); 3 parity error of oldest receive word; 4 framing error of oldest receive word; 5 overrun; 6 transmit not empty; 7 timeout; 8 receive at least half full (count >= 8); 9 transmit full.
- R6: A push into a full receive queue discards the new word and sets status bit 5. The next read of 0x08 clears the bit.
- R7: Register 0x10 holds a 9-bit enable mask. `irq_o` is the OR of status bits 0 to 8 ANDed with this mask.
- R8: Writing data with bit 0 set to 0x20 empties the transmit queue. Doing the same to 0x24 empties the receive queue and clears overrun and timeout. Writing with bit 0 clear has no effect.
- R9: With the 8-bit timeout register set to N > 0, status bit 7 sets after N `char_tick_i` pulses while the receive queue is non-empty and no receive push or pop occurs. Any receive push or pop clears it, and N = 0 disables it.
- R10: With `fifo_en_i` low, each queue holds one word. In that mode transmit half empty equals transmit empty, and receive half full equals receive not empty.
- R11: Writes to the status register and to the receive buffer change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fifo_en_i | input | 1 | 1: 16-entry queues, 0: single-entry holding |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rd_i | input | 1 | Register read strobe (pops receive data at 0x08) |
| reg_rdata_o | output | 16 | Register read data |
| rx_push_i | input | 1 | Receiver pushes a word |
| rx_data_i | input | 10 | Received word {frame err, parity err, data} |
| char_tick_i | input | 1 | One pulse per character period |
| tx_pop_i | input | 1 | Transmitter takes the oldest word |
| tx_data_o | output | 9 | Oldest transmit word |
| tx_valid_o | output | 1 | Transmit queue not empty |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check several rules on every cycle:
- queue counts stay within depth, and a push into a full queue leaves the count unchanged;
- a flush leaves its queue empty next cycle;
- an overflowing receive push raises overrun, and an uncontested receive read drops it;
- the timeout flag only stands while receive data is held, and it falls after any receive activity;
- an all-zero enable mask keeps the interrupt low.

Only the bench scenarios can show the rest:
- first-in first-out data order and the exact 16-word capacity;
- that the discarded overflow word is the newest;
- the half-level thresholds at 8;
- the tick count at which the timeout fires;
- the single-entry mode.

// File: rtl/uart_fs_pkg.sv
package uart_fs_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] OFS_TX  = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_RX  = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_IEN = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_STA = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_TMO = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_TXR = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_RXR = 6'h24;

  localparam int STA_W = 10;
  localparam int IEN_W = 9;

  localparam int ST_RX_NE   = 0;
  localparam int ST_TX_E    = 1;
  localparam int ST_TX_HE   = 2;
  localparam int ST_PERR    = 3;
  localparam int ST_FERR    = 4;
  localparam int ST_OVR     = 5;
  localparam int ST_TX_NE   = 6;
  localparam int ST_TMO     = 7;
  localparam int ST_RX_HF   = 8;
  localparam int ST_TX_FULL = 9;
endpackage

// File: rtl/uart_fs_fifo.sv
module uart_fs_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           flush_i,
  input  logic                           push_i,
  input  logic [W-1:0]                   wdata_i,
  input  logic                           pop_i,
  input  logic                           single_i,
  output logic [W-1:0]                   head_o,
  output logic [$clog2(DEPTH+1)-1:0]     cnt_o,
  output logic                           full_o,
  output logic                           empty_o,
  output logic                           push_ok_o,
  output logic                           pop_ok_o
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o   = (cnt_q == '0);
  assign full_o    = single_i ? !empty_o : (cnt_q == DEPTH_C);
  assign push_ok_o = push_i && !full_o && !flush_i;
  assign pop_ok_o  = pop_i && !empty_o && !flush_i;
  assign head_o    = mem_q[rptr_q];
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_ok_o) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok_o) wptr_q <= nxt(wptr_q);
      if (pop_ok_o)  rptr_q <= nxt(rptr_q);
      case ({push_ok_o, pop_ok_o})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R3: occupancy never exceeds the depth
  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= DEPTH_C);
  // R3: push into a full queue without a pop leaves the count unchanged
  a_r3_full_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> (cnt_q == $past(cnt_q)));
  // R8: flush leaves the queue empty
  a_r8_flush_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/uart_fs_timeout.sv
module uart_fs_timeout #(
  parameter int TMO_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             activity_i,
  input  logic             clear_i,
  input  logic             armed_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             flag_o
);
  logic [TMO_W-1:0] cnt_q;
  logic             flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (clear_i || activity_i || !armed_i) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (tick_i && (limit_i != '0) && !flag_q) begin
      if (cnt_q == limit_i - 1'b1) begin
        flag_q <= 1'b1;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign flag_o = flag_q;

  // R9: timeout stands only while receive data is held
  a_r9_flag_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o |-> armed_i);
  // R9: any receive activity drops the flag
  a_r9_activity_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    activity_i |=> !flag_o);
endmodule

// File: rtl/uart_fifo_status.sv
module uart_fifo_status
  import uart_fs_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int TX_W    = 9,
  parameter int RX_W    = 10,
  parameter int TMO_W   = 8,
  parameter int TMO_RST = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_en_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              reg_rd_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              rx_push_i,
  input  logic [RX_W-1:0]   rx_data_i,
  input  logic              char_tick_i,
  input  logic              tx_pop_i,
  output logic [TX_W-1:0]   tx_data_o,
  output logic              tx_valid_o,
  output logic              irq_o
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(DEPTH / 2);

  logic wr_tx, rd_rx, tx_flush, rx_flush, wr_ien, wr_tmo;
  assign wr_tx    = reg_wr_i && (reg_addr_i == OFS_TX);
  assign wr_ien   = reg_wr_i && (reg_addr_i == OFS_IEN);
  assign wr_tmo   = reg_wr_i && (reg_addr_i == OFS_TMO);
  assign tx_flush = reg_wr_i && (reg_addr_i == OFS_TXR) && reg_wdata_i[0];
  assign rx_flush = reg_wr_i && (reg_addr_i == OFS_RXR) && reg_wdata_i[0];
  assign rd_rx    = reg_rd_i && (reg_addr_i == OFS_RX);

  logic [TX_W-1:0]  tx_head;
  logic [CNT_W-1:0] tx_cnt;
  logic             tx_full, tx_empty, tx_push_ok, tx_pop_ok;
  logic [RX_W-1:0]  rx_head;
  logic [CNT_W-1:0] rx_cnt;
  logic             rx_full, rx_empty, rx_push_ok, rx_pop_ok;

  uart_fs_fifo #(.W(TX_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .flush_i   (tx_flush),
    .push_i    (wr_tx),
    .wdata_i   (reg_wdata_i[TX_W-1:0]),
    .pop_i     (tx_pop_i),
    .single_i  (!fifo_en_i),
    .head_o    (tx_head),
    .cnt_o     (tx_cnt),
    .full_o    (tx_full),
    .empty_o   (tx_empty),
    .push_ok_o (tx_push_ok),
    .pop_ok_o  (tx_pop_ok)
  );

  uart_fs_fifo #(.W(RX_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .flush_i   (rx_flush),
    .push_i    (rx_push_i),
    .wdata_i   (rx_data_i),
    .pop_i     (rd_rx),
    .single_i  (!fifo_en_i),
    .head_o    (rx_head),
    .cnt_o     (rx_cnt),
    .full_o    (rx_full),
    .empty_o   (rx_empty),
    .push_ok_o (rx_push_ok),
    .pop_ok_o  (rx_pop_ok)
  );

  logic [IEN_W-1:0] ien_q;
  logic [TMO_W-1:0] tmo_q;
  logic             ovr_q;
  logic             tmo_flag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= '0;
      tmo_q <= TMO_W'(TMO_RST);
    end else begin
      if (wr_ien) ien_q <= reg_wdata_i[IEN_W-1:0];
      if (wr_tmo) tmo_q <= reg_wdata_i[TMO_W-1:0];
    end
  end

  // set on a dropped push wins over a same-cycle read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      ovr_q <= 1'b0;
    else if (rx_flush)                ovr_q <= 1'b0;
    else if (rx_push_i && rx_full)    ovr_q <= 1'b1;
    else if (rd_rx)                   ovr_q <= 1'b0;
  end

  uart_fs_timeout #(.TMO_W(TMO_W)) u_tmo (
    .clk_i, .rst_ni,
    .tick_i     (char_tick_i),
    .activity_i (rx_push_ok || rx_pop_ok),
    .clear_i    (rx_flush),
    .armed_i    (!rx_empty),
    .limit_i    (tmo_q),
    .flag_o     (tmo_flag)
  );

  logic             tx_half_empty, rx_half_full;
  logic [STA_W-1:0] sta;

  assign tx_half_empty = fifo_en_i ? (tx_cnt <= HALF) : tx_empty;
  assign rx_half_full  = fifo_en_i ? (rx_cnt >= HALF) : !rx_empty;

  always_comb begin
    sta             = '0;
    sta[ST_RX_NE]   = !rx_empty;
    sta[ST_TX_E]    = tx_empty;
    sta[ST_TX_HE]   = tx_half_empty;
    sta[ST_PERR]    = !rx_empty && rx_head[8];
    sta[ST_FERR]    = !rx_empty && rx_head[9];
    sta[ST_OVR]     = ovr_q;
    sta[ST_TX_NE]   = !tx_empty;
    sta[ST_TMO]     = tmo_flag;
    sta[ST_RX_HF]   = rx_half_full;
    sta[ST_TX_FULL] = tx_full;
  end

  assign irq_o      = |(sta[IEN_W-1:0] & ien_q);
  assign tx_data_o  = tx_head;
  assign tx_valid_o = !tx_empty;

  always_comb begin
    case (reg_addr_i)
      OFS_RX:  reg_rdata_o = rx_empty ? '0 : DATA_W'(rx_head);
      OFS_STA: reg_rdata_o = DATA_W'(sta);
      OFS_IEN: reg_rdata_o = DATA_W'(ien_q);
      OFS_TMO: reg_rdata_o = DATA_W'(tmo_q);
      default: reg_rdata_o = '0;
    endcase
  end

  // R6: overflowing push raises overrun
  a_r6_overrun_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && rx_full && !rx_flush) |=> ovr_q);
  // R6: a receive read without overflow clears overrun
  a_r6_overrun_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rx && !(rx_push_i && rx_full)) |=> !ovr_q);
  // R7: zero mask keeps the line quiet
  a_r7_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |-> !irq_o);
  // R2: tx valid tracks presence of queued data
  a_r2_valid_after_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_push_ok && !tx_pop_i) |=> tx_valid_o);
endmodule

// File: tb/uart_fifo_status_tb_top.sv
module uart_fifo_status_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_en = 1'b1;
  logic [5:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rx_push = 1'b0;
  logic [9:0]  rx_data = '0;
  logic        tick = 1'b0;
  logic        tx_pop = 1'b0;
  logic [8:0]  tx_data;
  logic        tx_valid, irq;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  uart_fifo_status dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fifo_en),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rd_i(rd),
    .reg_rdata_o(rdata), .rx_push_i(rx_push), .rx_data_i(rx_data),
    .char_tick_i(tick), .tx_pop_i(tx_pop), .tx_data_o(tx_data),
    .tx_valid_o(tx_valid), .irq_o(irq)
  );

  localparam logic [3:0] OP_WR = 1, OP_RD = 2, OP_PUSH = 3, OP_POP = 4, OP_IRQ = 5;

  function automatic logic [47:0] v(input int r, input logic [3:0] op,
                                    input logic [7:0] a, input logic [15:0] d,
                                    input logic [15:0] e);
    return {4'(r), op, a, d, e};
  endfunction

  localparam int N = 28;
  localparam logic [47:0] VEC [N] = '{
    v(1,  OP_RD,   8'h14, 16'h000, 16'h006),  // R1 status reset
    v(1,  OP_RD,   8'h10, 16'h000, 16'h000),  // R1 enable reset
    v(1,  OP_IRQ,  8'h00, 16'h000, 16'h000),  // R1 irq low
    v(2,  OP_WR,   8'h04, 16'h1A5, 16'h000),  // R2
    v(5,  OP_RD,   8'h14, 16'h000, 16'h044),  // R5 one tx word
    v(2,  OP_WR,   8'h04, 16'h033, 16'h000),  // R2
    v(2,  OP_POP,  8'h00, 16'h000, 16'h1A5),  // R2 oldest first
    v(2,  OP_POP,  8'h00, 16'h000, 16'h033),  // R2
    v(5,  OP_RD,   8'h14, 16'h000, 16'h006),  // R5
    v(4,  OP_PUSH, 8'h00, 16'h155, 16'h000),  // R4 parity error word
    v(5,  OP_RD,   8'h14, 16'h000, 16'h00F),  // R5 bit3
    v(7,  OP_WR,   8'h10, 16'h001, 16'h000),  // R7
    v(7,  OP_RD,   8'h10, 16'h000, 16'h001),  // R7
    v(7,  OP_IRQ,  8'h00, 16'h000, 16'h001),  // R7
    v(4,  OP_RD,   8'h08, 16'h000, 16'h155),  // R4
    v(4,  OP_RD,   8'h14, 16'h000, 16'h006),  // R4 popped
    v(7,  OP_IRQ,  8'h00, 16'h000, 16'h000),  // R7
    v(4,  OP_PUSH, 8'h00, 16'h2AA, 16'h000),  // R4 framing error word
    v(5,  OP_RD,   8'h14, 16'h000, 16'h017),  // R5 bit4
    v(4,  OP_RD,   8'h08, 16'h000, 16'h2AA),  // R4
    v(4,  OP_RD,   8'h08, 16'h000, 16'h000),  // R4 empty read
    v(11, OP_WR,   8'h14, 16'h3FF, 16'h000),  // R11
    v(11, OP_RD,   8'h14, 16'h000, 16'h006),  // R11
    v(7,  OP_WR,   8'h10, 16'hFFFF, 16'h000), // R7
    v(7,  OP_RD,   8'h10, 16'h000, 16'h1FF),  // R7 9-bit mask
    v(7,  OP_IRQ,  8'h00, 16'h000, 16'h001),  // R7
    v(7,  OP_WR,   8'h10, 16'h000, 16'h000),  // R7
    v(7,  OP_IRQ,  8'h00, 16'h000, 16'h000)   // R7
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [5:0] a, output logic [15:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic push(input logic [9:0] d);
    rx_data = d; rx_push = 1'b1;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic pop(output logic [8:0] d);
    #1 d = tx_data;
    tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic chk_sta(input string req, input logic [15:0] exp);
    logic [15:0] s;
    rd_reg(6'h14, s);
    chk(req, s, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [8:0]  t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R1 tx_valid", {15'd0, tx_valid}, 16'd0);
    rd_reg(6'h1C, d); chk("R1 timeout reset", d, 16'd20);

    for (int i = 0; i < N; i++) begin
      string tag;
      logic [47:0] e;
      e = VEC[i];
      tag = $sformatf("R%0d row %0d", e[47:44], i);
      case (e[43:40])
        OP_WR:   wr_reg(e[37:32], e[31:16]);
        OP_RD:   begin rd_reg(e[37:32], d); chk(tag, d, e[15:0]); end
        OP_PUSH: push(e[25:16]);
        OP_POP:  begin pop(t); chk(tag, {7'd0, t}, e[15:0]); end
        OP_IRQ:  begin #1 chk(tag, {15'd0, irq}, e[15:0]); end
        default: ;
      endcase
    end

    // R3: fill beyond capacity, exactly 16 kept in order
    for (int i = 0; i < 20; i++) wr_reg(6'h04, 16'h100 + 16'(i));
    chk_sta("R3 full status", 16'h240);
    for (int i = 0; i < 16; i++) begin
      pop(t);
      chk("R3 order", {7'd0, t}, 16'h100 + 16'(i));
    end
    #1 chk("R3 drained", {15'd0, tx_valid}, 16'd0);

    // R6: overflow discards newest word
    for (int i = 0; i < 17; i++) push(10'(i));
    chk_sta("R6 overrun set", 16'h127);
    rd_reg(6'h08, d); chk("R6 first word", d, 16'd0);
    chk_sta("R6 overrun cleared", 16'h107);
    for (int i = 1; i < 16; i++) begin
      rd_reg(6'h08, d);
      chk("R6 remaining", d, 16'(i));
    end
    chk_sta("R6 empty", 16'h006);

    // R5: half-level thresholds
    for (int i = 0; i < 7; i++) push(10'h001);
    chk_sta("R5 rx 7", 16'h007);
    push(10'h001);
    chk_sta("R5 rx 8", 16'h107);
    wr_reg(6'h24, 16'h1);
    for (int i = 0; i < 8; i++) wr_reg(6'h04, 16'h055);
    chk_sta("R5 tx 8", 16'h044);
    wr_reg(6'h04, 16'h055);
    chk_sta("R5 tx 9", 16'h040);
    wr_reg(6'h20, 16'h1);

    // R8: flush registers
    for (int i = 0; i < 3; i++) wr_reg(6'h04, 16'h0AA);
    wr_reg(6'h20, 16'h0);
    chk_sta("R8 zero write ignored", 16'h044);
    wr_reg(6'h20, 16'h1);
    chk_sta("R8 tx flushed", 16'h006);
    for (int i = 0; i < 17; i++) push(10'h00F);
    wr_reg(6'h24, 16'h1);
    chk_sta("R8 rx flushed, overrun cleared", 16'h006);

    // R9: character timeout
    wr_reg(6'h1C, 16'd3);
    rd_reg(6'h1C, d); chk("R9 timeout reg", d, 16'd3);
    push(10'h011);
    ticks(2);
    chk_sta("R9 before limit", 16'h007);
    ticks(1);
    chk_sta("R9 at limit", 16'h087);
    wr_reg(6'h10, 16'h080);
    #1 chk("R9 irq", {15'd0, irq}, 16'd1);
    rd_reg(6'h08, d); chk("R9 data", d, 16'h011);
    chk_sta("R9 cleared by read", 16'h006);
    #1 chk("R9 irq low", {15'd0, irq}, 16'd0);
    push(10'h012);
    ticks(3);
    chk_sta("R9 set again", 16'h087);
    push(10'h013);
    chk_sta("R9 cleared by push", 16'h007);
    wr_reg(6'h24, 16'h1);
    wr_reg(6'h1C, 16'd0);
    push(10'h014);
    ticks(5);
    chk_sta("R9 disabled", 16'h007);
    wr_reg(6'h24, 16'h1);
    wr_reg(6'h10, 16'h0);

    // R10: single-entry mode
    fifo_en = 1'b0;
    wr_reg(6'h04, 16'h011);
    wr_reg(6'h04, 16'h022);
    chk_sta("R10 tx one full", 16'h240);
    pop(t); chk("R10 tx word", {7'd0, t}, 16'h011);
    #1 chk("R10 second dropped", {15'd0, tx_valid}, 16'd0);
    push(10'h033);
    push(10'h044);
    chk_sta("R10 rx overrun", 16'h127);
    rd_reg(6'h08, d); chk("R10 rx word", d, 16'h033);
    chk_sta("R10 empty", 16'h006);
    fifo_en = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule